// File: doc/BRIEF.md
# Token-Passing Sparsified Pixel Readout

This block is the digital half of a binary pixel matrix of 16 rows by 16 columns. It works in two alternating phases. While the detection phase runs, a shared 5-bit time stamp counter advances once per cell tick. Every pixel that sees a hit strobe latches that hit and freezes the counter value current at that tick. A pixel keeps only its first hit in a phase.

In the readout phase a token enters the first cell of the matrix. It ripples through every cell without a hit and stops at the first cell holding one. That cell drives its column and row selects and its stored time stamp onto the shared buses. The periphery shifts the column address, row address and time stamp out serially as one word. When the word is complete, the cell's latch clears and the token moves on to the next hit cell. After the token leaves the last cell, a done flag rises. A synchronous master reset prepares the matrix for the next detection phase.

The cell clock is modelled as an enable, `cell_en_i`, on the single block clock, and the serial output advances once per block clock.

Top module: `tpr_top`

## Requirements
- R1: After `rst_ni` low or a cycle with `mreset_i` high, all hit latches are clear and the time stamp counter is 0; `ser_o` and `frame_o` are low.
- R2: When `phase_i`=0 and `cell_en_i`=1, a rising clock edge with `hit_i[k]`=1 latches pixel k and stores the counter value before that edge. The counter then increments modulo 32. Pixel k sits at row y and column x with k = 16*y + x, both counted from 0.
- R3: A pixel already latched in the current detection phase ignores further hits, and keeps its first time stamp.
- R4: While `phase_i`=1, `hit_i` is ignored and the time stamp counter holds its value.
- R5: In the readout phase, exactly one word is emitted per latched pixel, in increasing index k. Pixels without a hit produce no word.
- R6: A word is 13 bits sent MSB first: x[3:0], then y[3:0], then the time stamp [4:0]. `frame_o` is high only during the first bit, and `ser_o` is low outside words.
- R7: Consecutive words start exactly 14 clock cycles apart: 13 bit cycles plus one cycle in which the token moves on.
- R8: `done_o` is high only when `phase_i`=1, no word is in flight and no latched pixel remains. With no hits it is high as soon as the readout phase begins. It is low during the detection phase.
- R9: With `cell_en_i`=0, no hit is captured and the counter does not advance.
- R10: Readout clears each reported pixel. A following detection phase without a master reset keeps counting from the frozen counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mreset_i | input | 1 | Synchronous master reset of latches, counter and serializer |
| phase_i | input | 1 | 0 = detection phase, 1 = readout phase |
| cell_en_i | input | 1 | Cell clock tick enable for capture and counting |
| hit_i | input | 256 | Per-pixel hit strobes, index 16*row + column |
| ser_o | output | 1 | Serial data output |
| frame_o | output | 1 | High during the first bit of each word |
| done_o | output | 1 | Token has left the last cell and the serializer is idle |

## Verification
The assertions assume that `phase_i` changes only while no word is in flight, which means during detection or after `done_o` rises. They also assume that `mreset_i` is not raised in the middle of a readout. The stimulus switches phase only at those points. Random hit patterns and random ticks are applied during detection. During readout, hit strobes are still driven, but only to test that they are ignored.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  localparam int unsigned DEF_ROWS = 16;
  localparam int unsigned DEF_COLS = 16;
  localparam int unsigned DEF_TS_W = 5;

  typedef enum logic {PH_DETECT = 1'b0, PH_READOUT = 1'b1} phase_e;
endpackage

// File: rtl/tpr_ts_counter.sv
module tpr_ts_counter #(
  parameter int unsigned TS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ts_o <= '0;
    else if (clr_i)  ts_o <= '0;
    else if (adv_i)  ts_o <= ts_o + 1'b1;  // wraps at 2**TS_W
  end
endmodule

// File: rtl/tpr_pixel_array.sv
module tpr_pixel_array #(
  parameter int unsigned N_ROWS = 16,
  parameter int unsigned N_COLS = 16,
  parameter int unsigned TS_W   = 5,
  localparam int unsigned N_PIX = N_ROWS * N_COLS,
  localparam int unsigned XW    = $clog2(N_COLS),
  localparam int unsigned YW    = $clog2(N_ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic             capture_i,
  input  logic [N_PIX-1:0] hit_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             tok_in_i,
  input  logic             release_i,
  output logic [N_PIX-1:0] latch_o,
  output logic [N_PIX-1:0] grant_o,
  output logic             tok_out_o,
  output logic [XW-1:0]    x_o,
  output logic [YW-1:0]    y_o,
  output logic [TS_W-1:0]  ts_o
);
  logic [N_PIX:0]    tok;
  logic [TS_W-1:0]   ts_q [N_PIX];
  logic [TS_W-1:0]   col_ts [N_COLS];

  assign tok[0] = tok_in_i;

  for (genvar k = 0; k < N_PIX; k++) begin : g_cell
    // token ripples through empty cells, stops at a latched one
    assign tok[k+1]   = tok[k] & ~latch_o[k];
    assign grant_o[k] = tok[k] &  latch_o[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        latch_o[k] <= 1'b0;
        ts_q[k]    <= '0;
      end else if (clr_all_i) begin
        latch_o[k] <= 1'b0;
        ts_q[k]    <= '0;
      end else if (release_i && grant_o[k]) begin
        latch_o[k] <= 1'b0;
      end else if (capture_i && hit_i[k] && !latch_o[k]) begin
        latch_o[k] <= 1'b1;
        ts_q[k]    <= ts_i;
      end
    end
  end

  assign tok_out_o = tok[N_PIX];

  // wired-OR address buses and per-column time stamp buses
  always_comb begin
    x_o = '0;
    y_o = '0;
    for (int c = 0; c < N_COLS; c++) col_ts[c] = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      for (int c = 0; c < N_COLS; c++) begin
        if (grant_o[r*N_COLS + c]) begin
          x_o       = x_o | XW'(c);
          y_o       = y_o | YW'(r);
          col_ts[c] = col_ts[c] | ts_q[r*N_COLS + c];
        end
      end
    end
  end

  always_comb begin
    ts_o = '0;
    for (int c = 0; c < N_COLS; c++)
      if (x_o == XW'(c)) ts_o = col_ts[c];
  end
endmodule

// File: rtl/tpr_serializer.sv
module tpr_serializer #(
  parameter int unsigned WW = 13,
  localparam int unsigned CW = $clog2(WW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          req_i,
  input  logic [WW-1:0] word_i,
  output logic          ser_o,
  output logic          frame_o,
  output logic          busy_o,
  output logic          release_o
);
  logic [WW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (clr_i) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (busy_o) begin
      sh_q <= sh_q << 1;
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (en_i && req_i) begin
      sh_q   <= word_i;
      cnt_q  <= CW'(WW-1);
      busy_o <= 1'b1;
    end
  end

  assign ser_o     = busy_o & sh_q[WW-1];
  assign frame_o   = busy_o && (cnt_q == CW'(WW-1));
  assign release_o = busy_o && (cnt_q == '0);  // last bit: holder lets token go
endmodule

// File: rtl/tpr_top.sv
module tpr_top
  import tpr_pkg::*;
#(
  parameter int unsigned N_ROWS = DEF_ROWS,
  parameter int unsigned N_COLS = DEF_COLS,
  parameter int unsigned TS_W   = DEF_TS_W,
  localparam int unsigned N_PIX = N_ROWS * N_COLS,
  localparam int unsigned XW    = $clog2(N_COLS),
  localparam int unsigned YW    = $clog2(N_ROWS),
  localparam int unsigned WW    = XW + YW + TS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic             phase_i,
  input  logic             cell_en_i,
  input  logic [N_PIX-1:0] hit_i,
  output logic             ser_o,
  output logic             frame_o,
  output logic             done_o
);
  logic             readout;
  logic             tick;
  logic [TS_W-1:0]  ts_q;
  logic [N_PIX-1:0] hit_q;
  logic [N_PIX-1:0] grant;
  logic             tok_out;
  logic [XW-1:0]    bus_x;
  logic [YW-1:0]    bus_y;
  logic [TS_W-1:0]  bus_ts;
  logic             busy;
  logic             release_tok;

  assign readout = (phase_e'(phase_i) == PH_READOUT);
  assign tick    = !readout && cell_en_i;

  tpr_ts_counter #(.TS_W(TS_W)) u_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mreset_i),
    .adv_i (tick),
    .ts_o  (ts_q)
  );

  tpr_pixel_array #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .TS_W(TS_W)) u_pix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_all_i(mreset_i),
    .capture_i(tick),
    .hit_i    (hit_i),
    .ts_i     (ts_q),
    .tok_in_i (readout),
    .release_i(release_tok),
    .latch_o  (hit_q),
    .grant_o  (grant),
    .tok_out_o(tok_out),
    .x_o      (bus_x),
    .y_o      (bus_y),
    .ts_o     (bus_ts)
  );

  tpr_serializer #(.WW(WW)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mreset_i),
    .en_i     (readout),
    .req_i    (!tok_out),
    .word_i   ({bus_x, bus_y, bus_ts}),
    .ser_o    (ser_o),
    .frame_o  (frame_o),
    .busy_o   (busy),
    .release_o(release_tok)
  );

  assign done_o = readout && tok_out && !busy;
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
  parameter int unsigned N    = 256,
  parameter int unsigned TS_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mreset_i,
  input logic            phase_i,
  input logic            ser_o,
  input logic            frame_o,
  input logic            done_o,
  input logic [N-1:0]    grant,
  input logic [N-1:0]    latch,
  input logic [TS_W-1:0] ts
);
  // R5: at most one cell holds the token
  a_r5_single_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R4: no new latches in readout phase
  a_r4_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> ($countones(latch) <= $past($countones(latch))));

  // R4: counter frozen during readout
  a_r4_ts_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i && !mreset_i) |=> $stable(ts));

  // R7: words are longer than one cycle, so frame never repeats back to back
  a_r7_frame_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  // R8: done implies nothing pending and a quiet line
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!frame_o && !ser_o && latch == '0));

  // R8: done only in readout phase
  a_r8_done_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |-> !done_o);

  // R1: master reset clears matrix and counter
  a_r1_mreset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (latch == '0 && ts == '0 && !frame_o));
endmodule

bind tpr_top tpr_checker #(.N(N_PIX), .TS_W(TS_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mreset_i(mreset_i),
  .phase_i (phase_i),
  .ser_o   (ser_o),
  .frame_o (frame_o),
  .done_o  (done_o),
  .grant   (grant),
  .latch   (hit_q),
  .ts      (ts_q)
);

// File: tb/tb_tpr_top.sv
module tb_tpr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mreset_i = 1'b0;
  logic          phase_i = 1'b0;
  logic          cell_en_i = 1'b0;
  logic [NP-1:0] hit_i = '0;
  logic          ser_o, frame_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model
  bit       m_lat [NP];
  bit [4:0] m_ts  [NP];
  bit [4:0] m_cnt;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tpr_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mreset_i(mreset_i), .phase_i(phase_i),
    .cell_en_i(cell_en_i), .hit_i(hit_i),
    .ser_o(ser_o), .frame_o(frame_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_clear();
    for (int k = 0; k < NP; k++) begin m_lat[k] = 0; m_ts[k] = 0; end
    m_cnt = 0;
  endfunction

  function automatic int model_count();
    int n = 0;
    for (int k = 0; k < NP; k++) n += m_lat[k];
    return n;
  endfunction

  function automatic logic [12:0] model_word(input int k);
    return {4'(k % 16), 4'(k / 16), m_ts[k]};
  endfunction

  task automatic do_mreset();
    @(negedge clk_i);
    mreset_i = 1'b1; hit_i = '0; cell_en_i = 1'b0;
    @(negedge clk_i);
    mreset_i = 1'b0;
    model_clear();
  endtask

  // one detection clock with given tick enable and hits
  task automatic det_cycle(input bit en, input logic [NP-1:0] h);
    hit_i = h; cell_en_i = en;
    if (en) begin
      for (int k = 0; k < NP; k++)
        if (h[k] && !m_lat[k]) begin m_lat[k] = 1; m_ts[k] = m_cnt; end
      m_cnt = m_cnt + 1;
    end
    @(negedge clk_i);
    hit_i = '0; cell_en_i = 1'b0;
  endtask

  task automatic rand_hits(output logic [NP-1:0] h, input int pct);
    for (int k = 0; k < NP; k++) h[k] = (($urandom % 1000) < pct);
  endtask

  // readout phase: decode serial stream and compare with model
  task automatic readout(input string tag, input bit inject);
    int exp_idx[$];
    int widx = 0, bitn = -1, last_frame = -1, cyc = 0;
    bit got_done = 0;
    logic [12:0] w = '0;
    logic [NP-1:0] junk;
    for (int k = 0; k < NP; k++) if (m_lat[k]) exp_idx.push_back(k);
    phase_i = 1'b1;
    while (cyc < 5000 && !got_done) begin
      if (inject) begin rand_hits(junk, 300); hit_i = junk; cell_en_i = 1'b1; end
      @(negedge clk_i);
      cyc++;
      if (bitn < 0) begin
        if (frame_o) begin
          if (last_frame >= 0)
            chk(cyc - last_frame == 14, "R7 word spacing", cyc - last_frame, 14);
          last_frame = cyc;
          w[12] = ser_o; bitn = 11;
        end else if (done_o) begin
          got_done = 1;
        end else if (ser_o) begin
          chk(0, "R6 ser_o high outside word", 1, 0);
        end
      end else begin
        if (frame_o) chk(0, "R6 frame_o inside word", 1, 0);
        if (done_o)  chk(0, "R8 done_o during word", 1, 0);
        w[bitn] = ser_o;
        if (bitn == 0) begin
          if (widx < exp_idx.size())
            chk(w == model_word(exp_idx[widx]), {tag, " R5 R6 word"}, int'(w),
                int'(model_word(exp_idx[widx])));
          else
            chk(0, {tag, " R5 extra word"}, int'(w), -1);
          widx++;
        end
        bitn--;
      end
    end
    hit_i = '0; cell_en_i = 1'b0;
    chk(got_done, {tag, " R8 done reached"}, got_done, 1);
    chk(widx == exp_idx.size(), {tag, " R5 word count"}, widx, exp_idx.size());
    // R10: reported pixels are cleared; counter kept
    for (int k = 0; k < NP; k++) m_lat[k] = 0;
    @(negedge clk_i);
    chk(done_o == 1'b1, {tag, " R8 done holds"}, done_o, 1);
    phase_i = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b0, {tag, " R8 done low in detection"}, done_o, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [NP-1:0] h;
    void'($urandom(32'h5EED_1234));
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(ser_o == 0 && frame_o == 0, "R1 outputs after reset", {ser_o, frame_o}, 0);
    chk(done_o == 0, "R8 done low after reset", done_o, 0);

    // R8: no hits -> done immediately
    readout("empty", 0);

    // first and last cells only, R1 counter starts at 0 after mreset
    do_mreset();
    h = '0; h[0] = 1'b1; det_cycle(1, h);
    det_cycle(1, '0);
    h = '0; h[NP-1] = 1'b1; det_cycle(1, h);
    readout("corners", 0);

    // R3: later hit on same pixel ignored; R9: no capture without tick
    do_mreset();
    h = '0; h[37] = 1'b1; det_cycle(1, h);
    det_cycle(1, '0); det_cycle(1, h); det_cycle(1, h);
    h = '0; h[200] = 1'b1; det_cycle(0, h); det_cycle(0, h);
    readout("R3 R9 repeat", 0);

    // R1: mreset after hits drops them
    h = '1; det_cycle(1, h);
    do_mreset();
    chk(model_count() == 0, "R1 model cleared", model_count(), 0);
    readout("R1 mreset", 0);

    // R2 wrap: 45 ticks with sparse hits, R4 injection during readout
    do_mreset();
    for (int t = 0; t < 45; t++) begin rand_hits(h, 8); det_cycle(1, h); end
    readout("R2 R4 wrap", 1);

    // R10: next detection without mreset continues counting
    for (int t = 0; t < 6; t++) begin rand_hits(h, 20); det_cycle(($urandom % 2) == 1, h); end
    readout("R10 continue", 0);

    // full matrix in 16 ticks, one row per tick
    do_mreset();
    for (int t = 0; t < 16; t++) begin
      h = '0;
      for (int c = 0; c < 16; c++) h[t*16 + c] = 1'b1;
      det_cycle(1, h);
    end
    readout("full", 0);

    // random rounds
    for (int r = 0; r < 6; r++) begin
      do_mreset();
      for (int t = 0; t < 20 + ($urandom % 30); t++) begin
        rand_hits(h, 5 + ($urandom % 40));
        det_cycle(($urandom % 4) != 0, h);
      end
      readout("random", r[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule